// File: doc/BRIEF.md
# Audio Sample Float Pack/Unpack Converter

This block converts between a 24-bit two's-complement audio sample and a 16-bit compressed floating word, in both directions. A word carries a sign bit, a 4-bit exponent and an 11-bit mantissa. The exponent records how many leading bits of the sample only repeat its sign. Samples of small magnitude keep their low-order bits, and large samples keep their top bits. Mantissa bits beyond the 11 kept are truncated.

The two directions are independent, and each is registered once. A packing request presents a sample with a valid strobe. One clock later the packed word appears with its own valid strobe. An unpacking request works the same way from a word to a sample. The decoder accepts every 16-bit code. Exponent codes above 11 are decoded as 11, and the decoded sample is always arithmetically sign-extended.

Top module: `afloat_conv`

## Requirements
- R1: While reset is asserted and after it is released, with no request made, both valid outputs are 0, the packed word output is 0 and the sample output is 0.
- R2: Each direction has a latency of exactly one clock. The output valid is high in the cycle after an input valid and low in the cycle after an idle input.
- R3: Bit 15 of the packed word equals bit 23 of the input sample.
- R4: Bits 14:11 of the packed word hold the exponent. The exponent is the number of leading zeros, counted from bit 23 downward, in the test word t = (x XOR (x<<1)) masked to 24 bits. At most 12 positions are examined.
- R5: Bits 10:0 of the packed word are bits 21:11 of the sample shifted left by min(exponent, 11).
- R6: A packed word never carries an exponent code above 12. Code 12 is produced when bits 23 down to 11 of the sample are all equal (for example for 0 → 16'h6000 and −1 → 16'hE7FF).
- R7: When unpacking a word with exponent e below 12, the block builds a signed 24-bit value with the sign at bit 23, the inverted sign at bit 22 and the mantissa at bits 21:11, with zeros below. It then shifts this value arithmetically right by e.
- R8: An exponent code of 12 to 15 decodes as 11. In that case bit 22 of the intermediate equals the sign, so the output is the mantissa at bits 10:0 with the sign replicated into bits 23:11. For example, 16'h7801 → 24'h000001 and 16'hF800 → 24'hFFF800.
- R9: The decoded sample is sign-extended: its bit 23 equals bit 15 of the word for every code.
- R10: Round trip. If a sample x packs to exponent e < 12, unpacking the packed word returns x with bits (10−e):0 cleared. If e = 12, it returns x exactly. For example, 24'h7FFFFF → 16'h07FF → 24'h7FF800, and 24'h800000 survives unchanged.
- R11: While an input valid is low, the data output of that direction keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pk_valid_i | input | 1 | Pack request strobe |
| pk_sample_i | input | 24 | Sample to compress (two's complement) |
| pk_valid_o | output | 1 | Packed word valid |
| pk_word_o | output | 16 | Packed word: sign 15, exponent 14:11, mantissa 10:0 |
| up_valid_i | input | 1 | Unpack request strobe |
| up_word_i | input | 16 | Word to expand |
| up_valid_o | output | 1 | Expanded sample valid |
| up_sample_o | output | 24 | Expanded, sign-extended sample |

## Verification
The bench builds the block with its default widths: a 24-bit sample, a 4-bit exponent, an 11-bit mantissa and a normalisation cap of 12. At these widths all sixteen exponent codes can be reached on the decode side, including the four clamped codes. On the encode side the bench reaches every exponent from 0 up to the cap. Fixed extremes (zero, full-scale positive and negative, −1) and the clamped codes exercise the cap and clamp boundaries. Random samples and words are compared against a model that counts repeated sign bits instead of scanning an XOR word. The bench also pushes random samples through both directions to test the truncation rule of the round trip.

// File: rtl/afloat_pkg.sv
package afloat_pkg;
  localparam int unsigned SMP_W    = 24;
  localparam int unsigned EXP_W    = 4;
  localparam int unsigned MAN_W    = 11;
  localparam int unsigned NORM_CAP = 12;
endpackage

// File: rtl/afloat_lsc.sv
// Counts leading positions of the sign-transition word that are zero,
// examining at most CAP positions from the top.
module afloat_lsc #(
  parameter int unsigned W   = afloat_pkg::SMP_W,
  parameter int unsigned CAP = afloat_pkg::NORM_CAP,
  parameter int unsigned CW  = afloat_pkg::EXP_W
) (
  input  logic [W-1:0]  val_i,
  output logic [CW-1:0] cnt_o
);
  logic [W-1:0] probe;
  logic         hit;

  assign probe = val_i ^ {val_i[W-2:0], 1'b0};

  always_comb begin
    hit   = 1'b0;
    cnt_o = '0;
    for (int k = 0; k < CAP; k++) begin
      if (!hit) begin
        if (probe[W-1-k]) hit = 1'b1;
        else              cnt_o = cnt_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/afloat_packer.sv
module afloat_packer #(
  parameter int unsigned SMP_W    = afloat_pkg::SMP_W,
  parameter int unsigned EXP_W    = afloat_pkg::EXP_W,
  parameter int unsigned MAN_W    = afloat_pkg::MAN_W,
  parameter int unsigned NORM_CAP = afloat_pkg::NORM_CAP,
  localparam int unsigned WORD_W  = 1 + EXP_W + MAN_W
) (
  input  logic [SMP_W-1:0]  smp_i,
  output logic [WORD_W-1:0] word_o,
  output logic [EXP_W-1:0]  exp_o
);
  localparam int unsigned MAX_SH  = NORM_CAP - 1;
  localparam int unsigned MAN_LSB = SMP_W - 2 - MAN_W;

  function automatic logic [MAN_W-1:0] take_mant(input logic [SMP_W-1:0] v,
                                                 input logic [EXP_W-1:0] sh);
    logic [SMP_W-1:0] moved;
    moved = v << sh;
    return moved[MAN_LSB +: MAN_W];
  endfunction

  logic [EXP_W-1:0] sh_amt;

  afloat_lsc #(.W(SMP_W), .CAP(NORM_CAP), .CW(EXP_W)) u_lsc (
    .val_i (smp_i),
    .cnt_o (exp_o)
  );

  assign sh_amt = (exp_o > EXP_W'(MAX_SH)) ? EXP_W'(MAX_SH) : exp_o;
  assign word_o = {smp_i[SMP_W-1], exp_o, take_mant(smp_i, sh_amt)};
endmodule

// File: rtl/afloat_unpacker.sv
module afloat_unpacker #(
  parameter int unsigned SMP_W    = afloat_pkg::SMP_W,
  parameter int unsigned EXP_W    = afloat_pkg::EXP_W,
  parameter int unsigned MAN_W    = afloat_pkg::MAN_W,
  parameter int unsigned NORM_CAP = afloat_pkg::NORM_CAP,
  localparam int unsigned WORD_W  = 1 + EXP_W + MAN_W
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [SMP_W-1:0]  smp_o,
  output logic              clamp_o
);
  localparam int unsigned MAX_SH  = NORM_CAP - 1;
  localparam int unsigned MAN_LSB = SMP_W - 2 - MAN_W;

  // Signed intermediate so that the right shift replicates the sign.
  function automatic logic [SMP_W-1:0] expand(input logic s, input logic clamp,
                                              input logic [MAN_W-1:0] m,
                                              input logic [EXP_W-1:0] sh);
    logic signed [SMP_W-1:0] mid;
    mid = {s, (clamp ? s : ~s), m, {MAN_LSB{1'b0}}};
    return mid >>> sh;
  endfunction

  logic             sgn;
  logic [EXP_W-1:0] expo;
  logic [EXP_W-1:0] sh_amt;
  logic [MAN_W-1:0] mant;

  assign sgn     = word_i[WORD_W-1];
  assign expo    = word_i[MAN_W +: EXP_W];
  assign mant    = word_i[MAN_W-1:0];
  assign clamp_o = (expo > EXP_W'(MAX_SH));
  assign sh_amt  = clamp_o ? EXP_W'(MAX_SH) : expo;
  assign smp_o   = expand(sgn, clamp_o, mant, sh_amt);
endmodule

// File: rtl/afloat_conv.sv
module afloat_conv #(
  parameter int unsigned SMP_W    = afloat_pkg::SMP_W,
  parameter int unsigned EXP_W    = afloat_pkg::EXP_W,
  parameter int unsigned MAN_W    = afloat_pkg::MAN_W,
  parameter int unsigned NORM_CAP = afloat_pkg::NORM_CAP,
  localparam int unsigned WORD_W  = 1 + EXP_W + MAN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pk_valid_i,
  input  logic [SMP_W-1:0]  pk_sample_i,
  output logic              pk_valid_o,
  output logic [WORD_W-1:0] pk_word_o,
  input  logic              up_valid_i,
  input  logic [WORD_W-1:0] up_word_i,
  output logic              up_valid_o,
  output logic [SMP_W-1:0]  up_sample_o
);
  logic [WORD_W-1:0] pk_word_w;
  logic [EXP_W-1:0]  pk_exp_w;
  logic [SMP_W-1:0]  up_sample_w;
  logic              up_clamp_w;

  afloat_packer #(.SMP_W(SMP_W), .EXP_W(EXP_W), .MAN_W(MAN_W),
                  .NORM_CAP(NORM_CAP)) u_pack (
    .smp_i  (pk_sample_i),
    .word_o (pk_word_w),
    .exp_o  (pk_exp_w)
  );

  afloat_unpacker #(.SMP_W(SMP_W), .EXP_W(EXP_W), .MAN_W(MAN_W),
                    .NORM_CAP(NORM_CAP)) u_unpack (
    .word_i  (up_word_i),
    .smp_o   (up_sample_w),
    .clamp_o (up_clamp_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pk_valid_o  <= 1'b0;
      pk_word_o   <= '0;
      up_valid_o  <= 1'b0;
      up_sample_o <= '0;
    end else begin
      pk_valid_o <= pk_valid_i;
      up_valid_o <= up_valid_i;
      if (pk_valid_i) pk_word_o   <= pk_word_w;
      if (up_valid_i) up_sample_o <= up_sample_w;
    end
  end
endmodule

// File: rtl/afloat_conv_chk.sv
module afloat_conv_chk #(
  parameter int unsigned SMP_W    = 24,
  parameter int unsigned EXP_W    = 4,
  parameter int unsigned MAN_W    = 11,
  parameter int unsigned NORM_CAP = 12,
  localparam int unsigned WORD_W  = 1 + EXP_W + MAN_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pk_valid_i,
  input logic [SMP_W-1:0]  pk_sample_i,
  input logic              pk_valid_o,
  input logic [WORD_W-1:0] pk_word_o,
  input logic              up_valid_i,
  input logic [WORD_W-1:0] up_word_i,
  input logic              up_valid_o,
  input logic [SMP_W-1:0]  up_sample_o,
  input logic              up_clamp
);
  a_r2_pk_valid: assert property (@(posedge clk) disable iff (!rst_n)
    pk_valid_i |=> pk_valid_o);
  a_r2_pk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !pk_valid_i |=> !pk_valid_o);
  a_r2_up_valid: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid_i |=> up_valid_o);
  a_r2_up_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid_i |=> !up_valid_o);
  a_r3_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    pk_valid_i |=> pk_word_o[WORD_W-1] == $past(pk_sample_i[SMP_W-1]));
  a_r6_exp_cap: assert property (@(posedge clk) disable iff (!rst_n)
    pk_valid_o |-> pk_word_o[MAN_W +: EXP_W] <= EXP_W'(NORM_CAP));
  a_r7_zero_exp: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid_i && up_word_i[MAN_W +: EXP_W] == '0) |=>
    up_sample_o == {$past(up_word_i[WORD_W-1]), ~$past(up_word_i[WORD_W-1]),
                    $past(up_word_i[MAN_W-1:0]), {(SMP_W-2-MAN_W){1'b0}}});
  a_r8_clamp_low: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid_i && up_clamp) |=> up_sample_o[MAN_W-1:0] == $past(up_word_i[MAN_W-1:0]));
  a_r8_clamp_high: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid_i && up_clamp) |=>
    up_sample_o[SMP_W-1:MAN_W] == {(SMP_W-MAN_W){up_sample_o[SMP_W-1]}});
  a_r9_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid_i |=> up_sample_o[SMP_W-1] == $past(up_word_i[WORD_W-1]));
  a_r11_pk_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pk_valid_i |=> $stable(pk_word_o));
  a_r11_up_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid_i |=> $stable(up_sample_o));
endmodule

bind afloat_conv afloat_conv_chk #(.SMP_W(SMP_W), .EXP_W(EXP_W), .MAN_W(MAN_W),
                                   .NORM_CAP(NORM_CAP)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pk_valid_i  (pk_valid_i),
  .pk_sample_i (pk_sample_i),
  .pk_valid_o  (pk_valid_o),
  .pk_word_o   (pk_word_o),
  .up_valid_i  (up_valid_i),
  .up_word_i   (up_word_i),
  .up_valid_o  (up_valid_o),
  .up_sample_o (up_sample_o),
  .up_clamp    (up_clamp_w)
);

// File: tb/afloat_conv_tb.sv
`timescale 1ns/1ps
module afloat_conv_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pk_valid_i = 1'b0;
  logic [23:0] pk_sample_i = '0;
  logic        pk_valid_o;
  logic [15:0] pk_word_o;
  logic        up_valid_i = 1'b0;
  logic [15:0] up_word_i = '0;
  logic        up_valid_o;
  logic [23:0] up_sample_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  afloat_conv u_dut (
    .clk(clk), .rst_n(rst_n),
    .pk_valid_i(pk_valid_i), .pk_sample_i(pk_sample_i),
    .pk_valid_o(pk_valid_o), .pk_word_o(pk_word_o),
    .up_valid_i(up_valid_i), .up_word_i(up_word_i),
    .up_valid_o(up_valid_o), .up_sample_o(up_sample_o)
  );

  // Directed pack pairs {sample, word}: R3 R4 R5 R6
  localparam logic [39:0] PK_TAB [7] = '{
    {24'h000000, 16'h6000}, {24'h7FFFFF, 16'h07FF}, {24'h800000, 16'h8000},
    {24'hFFFFFF, 16'hE7FF}, {24'h000001, 16'h6001}, {24'h400000, 16'h0000},
    {24'hC00000, 16'h8800}
  };
  // Directed unpack pairs {word, sample}: R7 R8
  localparam logic [39:0] UP_TAB [7] = '{
    {16'h6000, 24'h000000}, {16'h07FF, 24'h7FF800}, {16'h8000, 24'h800000},
    {16'hE7FF, 24'hFFFFFF}, {16'h7801, 24'h000001}, {16'hF800, 24'hFFF800},
    {16'h8800, 24'hC00000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Exponent by counting bits under the sign that repeat it.
  function automatic int ref_exp(input logic [23:0] x);
    int e;
    e = 0;
    while (e < 12 && x[22-e] == x[23]) e++;
    return e;
  endfunction

  function automatic logic [15:0] ref_pack(input logic [23:0] x);
    int e;
    logic [23:0] y;
    e = ref_exp(x);
    y = x << ((e > 11) ? 11 : e);
    return {x[23], 4'(e), y[21:11]};
  endfunction

  function automatic logic [23:0] ref_unpack(input logic [15:0] w);
    int e;
    int v;
    e = int'(w[14:11]);
    v = int'(w[10:0]) * 2048;
    if (e > 11) begin
      e = 11;
      if (w[15]) v = v - (1 << 22);
    end else begin
      v = w[15] ? v - (1 << 23) : v + (1 << 22);
    end
    return 24'(v >>> e);
  endfunction

  task automatic do_pack(input logic [23:0] x);
    @(negedge clk);
    pk_valid_i = 1'b1; pk_sample_i = x;
    @(posedge clk); #1;
    pk_valid_i = 1'b0;
  endtask

  task automatic do_unpack(input logic [15:0] w);
    @(negedge clk);
    up_valid_i = 1'b1; up_word_i = w;
    @(posedge clk); #1;
    up_valid_i = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 pk_valid_o in reset", 32'(pk_valid_o), 0);
    chk("R1 up_valid_o in reset", 32'(up_valid_o), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 pk_word_o after reset", 32'(pk_word_o), 0);
    chk("R1 up_sample_o after reset", 32'(up_sample_o), 0);
    chk("R1 pk_valid_o idle", 32'(pk_valid_o), 0);

    for (int i = 0; i < 7; i++) begin
      do_pack(PK_TAB[i][39:16]);
      chk("R2 pk_valid_o", 32'(pk_valid_o), 1);
      chk("R4 R5 R6 pack table", 32'(pk_word_o), 32'(PK_TAB[i][15:0]));
      do_unpack(UP_TAB[i][39:24]);
      chk("R2 up_valid_o", 32'(up_valid_o), 1);
      chk("R7 R8 unpack table", 32'(up_sample_o), 32'(UP_TAB[i][23:0]));
    end

    // R11: idle cycle with new data must not disturb outputs
    do_pack(24'h123456);
    do_unpack(16'h1234);
    @(negedge clk);
    pk_sample_i = 24'hABCDEF; up_word_i = 16'hFFFF;
    @(posedge clk); #1;
    chk("R2 pk_valid_o idle", 32'(pk_valid_o), 0);
    chk("R2 up_valid_o idle", 32'(up_valid_o), 0);
    chk("R11 pk_word_o hold", 32'(pk_word_o), 32'(ref_pack(24'h123456)));
    chk("R11 up_sample_o hold", 32'(up_sample_o), 32'(ref_unpack(16'h1234)));

    // R8: every clamped code decodes like code 12
    for (int c = 12; c < 16; c++) begin
      do_unpack({1'b1, 4'(c), 11'h2A5});
      chk("R8 clamp code", 32'(up_sample_o), 32'(ref_unpack({1'b1, 4'd12, 11'h2A5})));
      chk("R9 sign extend", 32'(up_sample_o[23]), 1);
    end

    // R4 R5: each exponent from 0 to 12 on pack
    for (int e = 0; e <= 12; e++) begin
      logic [23:0] x;
      x = (24'h5A5A5A >> e) | (24'h1 << (22 - ((e > 11) ? 11 : e)));
      if (e == 12) x = 24'h0005A5;
      x[23] = 1'b0;
      do_pack(x);
      chk("R4 exponent sweep", 32'(pk_word_o[14:11]), 32'(ref_exp(x)));
      chk("R5 mantissa sweep", 32'(pk_word_o), 32'(ref_pack(x)));
      do_pack(~x);
      chk("R3 R4 negative sweep", 32'(pk_word_o), 32'(ref_pack(~x)));
    end

    // Random pack, unpack and round trip: R3 R5 R7 R9 R10
    for (int i = 0; i < 300; i++) begin
      logic [23:0] x;
      logic [15:0] w;
      logic [23:0] keep;
      int e;
      x = 24'($urandom);
      if (i % 3 == 1) x = 24'($signed(x) >>> (i % 23));
      do_pack(x);
      chk("R3 R4 R5 random pack", 32'(pk_word_o), 32'(ref_pack(x)));
      w = pk_word_o;
      do_unpack(w);
      e = ref_exp(x);
      keep = (e >= 12) ? 24'hFFFFFF : ~((24'h1 << (11 - e)) - 24'h1);
      chk("R10 round trip", 32'(up_sample_o), 32'(x & keep));
      w = 16'($urandom);
      do_unpack(w);
      chk("R7 R8 random unpack", 32'(up_sample_o), 32'(ref_unpack(w)));
      chk("R9 sign extend random", 32'(up_sample_o[23]), 32'(w[15]));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule